// File: doc/BRIEF.md
# Lookup-Table Logic Cell

This block is one programmable logic cell. Two 16-entry truth tables, called F and G, each turn four logic inputs into one bit, so each can realise any Boolean function of its own four inputs. A third table, H, has 8 entries. It combines three bits, and configuration picks each of those bits from the F result, the G result or a single external input. A result register can capture the F, G or H result or the external input. Each of the two logic outputs shows either a combinational result or the register value.

A one-bit serial chain carries all contents and selections into the cell, on the cell clock while the load enable is high. The same chain also sets a mode. In the two memory modes the F and G tables stop acting as fixed functions and become user-writable storage. In the first, they form a 16-word by 2-bit memory with a write/read port and a second read-only port. In the second, they form a 32-word by 1-bit single-port memory. Carry logic and routing are outside this block.

Top module: `lut_cell`

## Requirements
- R1: While `cfgEn` is high, every rising edge shifts `cfgData` in at the top of a 54-bit chain, and bit 0 is the bit shifted in first. Chain layout from bit 0 upward: F table entries 0..15 [15:0], G table entries 0..15 [31:16], H table entries 0..7 [39:32], H input selects s0 [41:40], s1 [43:42], s2 [45:44], X-takes-H [46], Y-takes-H [47], register source [49:48], X-from-register [50], Y-from-register [51], mode [53:52].
- R2: In logic mode (mode 0 or 3), the F result is F table entry `fIn` and the G result is G table entry `gIn`. With X-takes-H = 0, `xOut` shows the F result. With Y-takes-H = 0, `yOut` shows the G result.
- R3: H input bit i is selected by si: 0 = F result, 1 = G result, 2 = `hExt`, 3 = constant 0. The H result is H table entry {h2,h1,h0}.
- R4: When X-takes-H (or Y-takes-H) is 1, the matching output shows the H result. When X-from-register (or Y-from-register) is 1, that output shows the register value instead of any combinational result.
- R5: On a rising edge with `regCe` high and `cfgEn` low, the register loads its selected source: 0 = F result, 1 = G result, 2 = H result, 3 = `hExt`. Otherwise the register keeps its value, and `qOut` shows it.
- R6: The register resets synchronously to 0 when `regRst` is high, and reset takes priority over `regCe`.
- R7: While `cfgEn` is high, `xOut`, `yOut`, `qOut` and `rdB` are all 0, the register does not load, and no memory write happens.
- R8: In mode 1 (16x2 dual port), a rising edge with `wrEn` high writes `wrData[0]` to F entry `fIn` and `wrData[1]` to G entry `fIn`. Port A reads combinationally: the F result is F entry `fIn` and the G result is G entry `fIn`.
- R9: In mode 1, `rdB` is {G entry `gIn`, F entry `gIn`}. It reads the same contents port A writes, and a write is visible on the cycle after its edge.
- R10: In mode 2 (32x1 single port), the address is {`hExt`,`fIn`}. `hExt`=0 reaches F and `hExt`=1 reaches G. A write stores `wrData[0]`, the F result is the addressed bit, and the G result is 0.
- R11: In logic mode, `wrEn` has no effect on either table.
- R12: `rdB` is 0 in every mode other than mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock for the chain, memory writes and register |
| cfgEn | input | 1 | Configuration load enable |
| cfgData | input | 1 | Serial configuration bit |
| fIn | input | 4 | F table inputs; write and port A address in memory modes |
| gIn | input | 4 | G table inputs; port B address in mode 1 |
| hExt | input | 1 | External H input; fifth address bit in mode 2 |
| wrEn | input | 1 | Memory write enable |
| wrData | input | 2 | Write data (bit 1 only used in mode 1) |
| regCe | input | 1 | Register clock enable |
| regRst | input | 1 | Register synchronous reset |
| xOut | output | 1 | X output |
| yOut | output | 1 | Y output |
| qOut | output | 1 | Register output |
| rdB | output | 2 | Second read port of the 16x2 memory |

## Verification
The bench sweeps every input combination under several table contents and H select patterns. A chain that packs bits in the wrong order, or a select decoder with swapped codes, produces wrong output bits somewhere in those sweeps. It reloads the configuration while `regCe` is held high, which catches a register that keeps loading during the load or outputs that leak through it. In both memory modes it fills every address and reads each one back. This exposes port B reading the wrong table, a lost fifth address bit, and writes that reach the tables in logic mode.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int LUT_IN = 4;
  localparam int LUT_SZ = 1 << LUT_IN;
  localparam int H_IN   = 3;
  localparam int H_SZ   = 1 << H_IN;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'd0,
    MODE_DP    = 2'd1,
    MODE_SP    = 2'd2,
    MODE_LOGIC2 = 2'd3
  } cellMode_e;

  // Packed so bit 0 is the F table entry 0 (first bit shifted in).
  typedef struct packed {
    cellMode_e                   mode;
    logic                        yUseQ;
    logic                        xUseQ;
    logic [SEL_W-1:0]            dSel;
    logic                        yTakeH;
    logic                        xTakeH;
    logic [H_IN-1:0][SEL_W-1:0]  hSel;
    logic [H_SZ-1:0]             hTab;
    logic [LUT_SZ-1:0]           gTab;
    logic [LUT_SZ-1:0]           fTab;
  } cellCfg_t;

  localparam int CFG_W  = $bits(cellCfg_t);
  localparam int CFG_IW = $clog2(CFG_W);
  localparam int F_BASE = 0;
  localparam int G_BASE = LUT_SZ;

  typedef struct packed {
    logic shift;
    logic blank;
    logic wrF;
    logic wrG;
    logic wrGHi;
    logic fFromG;
    logic gZero;
    logic gAddrA;
    logic portB;
    logic qLoad;
    logic qClear;
  } cellStrobe_t;
endpackage

// File: rtl/lut_cell_ctrl.sv
module lut_cell_ctrl
  import lut_cell_pkg::*;
(
  input  cellMode_e   mode,
  input  logic        cfgEn,
  input  logic        wrEn,
  input  logic        hExt,
  input  logic        regCe,
  input  logic        regRst,
  output cellStrobe_t st
);
  logic wrOk;
  assign wrOk = wrEn && !cfgEn;

  always_comb begin
    st        = '0;
    st.shift  = cfgEn;
    st.blank  = cfgEn;
    st.qClear = regRst;
    st.qLoad  = regCe && !cfgEn;
    case (mode)
      MODE_DP: begin
        st.wrF    = wrOk;
        st.wrG    = wrOk;
        st.wrGHi  = 1'b1;
        st.gAddrA = 1'b1;
        st.portB  = 1'b1;
      end
      MODE_SP: begin
        st.wrF    = wrOk && !hExt;
        st.wrG    = wrOk && hExt;
        st.fFromG = hExt;
        st.gZero  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lut_cell_dp.sv
module lut_cell_dp
  import lut_cell_pkg::*;
(
  input  logic              clk,
  input  cellStrobe_t       st,
  input  logic              cfgData,
  input  logic [LUT_IN-1:0] fIn,
  input  logic [LUT_IN-1:0] gIn,
  input  logic              hExt,
  input  logic [1:0]        wrData,
  output cellMode_e         mode,
  output logic              xOut,
  output logic              yOut,
  output logic              qOut,
  output logic [1:0]        rdB
);
  logic [CFG_W-1:0]  cfgQ;
  cellCfg_t          cf;
  logic [CFG_IW-1:0] fWrIdx, gWrIdx;
  logic [LUT_IN-1:0] gAddr;
  logic              fVal, gVal, hVal, dVal, qReg, cx, cy;
  logic [H_IN-1:0]   hIdx;

  assign cf     = cellCfg_t'(cfgQ);
  assign mode   = cf.mode;
  assign fWrIdx = CFG_IW'(F_BASE) + CFG_IW'(fIn);
  assign gWrIdx = CFG_IW'(G_BASE) + CFG_IW'(fIn);

  // Chain shift and RAM writes share one storage vector.
  always_ff @(posedge clk) begin
    if (st.shift) begin
      cfgQ <= {cfgData, cfgQ[CFG_W-1:1]};
    end else begin
      if (st.wrF) cfgQ[fWrIdx] <= wrData[0];
      if (st.wrG) cfgQ[gWrIdx] <= st.wrGHi ? wrData[1] : wrData[0];
    end
  end

  assign fVal  = st.fFromG ? cf.gTab[fIn] : cf.fTab[fIn];
  assign gAddr = st.gAddrA ? fIn : gIn;
  assign gVal  = st.gZero ? 1'b0 : cf.gTab[gAddr];

  for (genvar i = 0; i < H_IN; i++) begin : g_hsel
    assign hIdx[i] = (cf.hSel[i] == 2'd0) ? fVal :
                     (cf.hSel[i] == 2'd1) ? gVal :
                     (cf.hSel[i] == 2'd2) ? hExt : 1'b0;
  end
  assign hVal = cf.hTab[hIdx];

  always_comb begin
    case (cf.dSel)
      2'd0:    dVal = fVal;
      2'd1:    dVal = gVal;
      2'd2:    dVal = hVal;
      default: dVal = hExt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (st.qClear)     qReg <= 1'b0;
    else if (st.qLoad) qReg <= dVal;
  end

  assign cx   = cf.xTakeH ? hVal : fVal;
  assign cy   = cf.yTakeH ? hVal : gVal;
  assign xOut = !st.blank && (cf.xUseQ ? qReg : cx);
  assign yOut = !st.blank && (cf.yUseQ ? qReg : cy);
  assign qOut = !st.blank && qReg;
  assign rdB  = (st.portB && !st.blank) ? {cf.gTab[gIn], cf.fTab[gIn]} : 2'b00;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic              clk,
  input  logic              cfgEn,
  input  logic              cfgData,
  input  logic [LUT_IN-1:0] fIn,
  input  logic [LUT_IN-1:0] gIn,
  input  logic              hExt,
  input  logic              wrEn,
  input  logic [1:0]        wrData,
  input  logic              regCe,
  input  logic              regRst,
  output logic              xOut,
  output logic              yOut,
  output logic              qOut,
  output logic [1:0]        rdB
);
  cellMode_e   cellMode;
  cellStrobe_t strobes;

  lut_cell_ctrl u_ctrl (
    .mode(cellMode), .cfgEn(cfgEn), .wrEn(wrEn), .hExt(hExt),
    .regCe(regCe), .regRst(regRst), .st(strobes)
  );

  lut_cell_dp u_dp (
    .clk(clk), .st(strobes), .cfgData(cfgData), .fIn(fIn), .gIn(gIn),
    .hExt(hExt), .wrData(wrData), .mode(cellMode), .xOut(xOut),
    .yOut(yOut), .qOut(qOut), .rdB(rdB)
  );
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
  import lut_cell_pkg::*;
(
  input logic              clk,
  input logic              regRst,
  input logic              cfgEn,
  input logic              wrEn,
  input logic [LUT_IN-1:0] fIn,
  input logic [LUT_IN-1:0] gIn,
  input logic [1:0]        wrData,
  input logic              regCe,
  input logic              xOut,
  input logic              yOut,
  input logic              qOut,
  input logic [1:0]        rdB,
  input cellMode_e         cellMode
);
  logic pastRst = 1'b0;

  always_ff @(posedge clk) begin
    pastRst <= regRst;
    if (pastRst && !cfgEn)
      assert_reset_R6: assert (qOut == 1'b0);
  end

  assert_blank_R7: assert property (@(posedge clk) disable iff (regRst)
    cfgEn |-> (xOut == 1'b0 && yOut == 1'b0 && qOut == 1'b0 && rdB == 2'b00));

  assert_hold_R5: assert property (@(posedge clk) disable iff (regRst)
    (!cfgEn && !regCe) |=> (cfgEn || $stable(qOut)));

  assert_dp_write_R9: assert property (@(posedge clk) disable iff (regRst)
    (!cfgEn && wrEn && cellMode == MODE_DP) |=>
      (cfgEn || gIn != $past(fIn) || rdB == $past(wrData)));

  assert_no_rdb_R12: assert property (@(posedge clk) disable iff (regRst)
    (cellMode != MODE_DP) |-> (rdB == 2'b00));
endmodule

bind lut_cell lut_cell_chk u_chk (
  .clk(clk), .regRst(regRst), .cfgEn(cfgEn), .wrEn(wrEn), .fIn(fIn),
  .gIn(gIn), .wrData(wrData), .regCe(regCe), .xOut(xOut), .yOut(yOut),
  .qOut(qOut), .rdB(rdB), .cellMode(cellMode)
);

// File: tb/sim_lut_cell.sv
`timescale 1ns/1ps
module sim_lut_cell;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       cfgEn = 0, cfgData = 0, hExt = 0, wrEn = 0, regCe = 0, regRst = 0;
  logic [3:0] fIn = 0, gIn = 0;
  logic [1:0] wrData = 0;
  logic       xOut, yOut, qOut;
  logic [1:0] rdB;

  lut_cell u0 (.*);

  int nVec = 0, nBad = 0;
  bit done = 0;

  // independent model of the cell
  logic [15:0] mF, mG;
  logic [7:0]  mH;
  logic [1:0]  mS0, mS1, mS2, mD, mMd;
  logic        mXH, mYH, mXQ, mYQ, mQ = 0;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [53:0] mkCfg(logic [15:0] f, logic [15:0] g, logic [7:0] h,
      logic [1:0] s0, logic [1:0] s1, logic [1:0] s2, logic xh, logic yh,
      logic [1:0] ds, logic xq, logic yq, logic [1:0] md);
    return {md, yq, xq, ds, yh, xh, s2, s1, s0, h, g, f};
  endfunction

  function automatic logic eF();
    if (mMd == 2'd2) return hExt ? mG[fIn] : mF[fIn];
    return mF[fIn];
  endfunction
  function automatic logic eG();
    if (mMd == 2'd1) return mG[fIn];
    if (mMd == 2'd2) return 1'b0;
    return mG[gIn];
  endfunction
  function automatic logic eSel(logic [1:0] s);
    case (s)
      2'd0: return eF();
      2'd1: return eG();
      2'd2: return hExt;
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic eH();
    return mH[{eSel(mS2), eSel(mS1), eSel(mS0)}];
  endfunction
  function automatic logic eD();
    case (mD)
      2'd0: return eF();
      2'd1: return eG();
      2'd2: return eH();
      default: return hExt;
    endcase
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h (fIn=%0h gIn=%0h hExt=%0b)",
               req, act, exp, fIn, gIn, hExt);
    end
  endtask

  // check all outputs, then advance one clock with the model
  task automatic cycle(string req);
    logic ex, ey, d;
    #1;
    ex = cfgEn ? 1'b0 : (mXQ ? mQ : (mXH ? eH() : eF()));
    ey = cfgEn ? 1'b0 : (mYQ ? mQ : (mYH ? eH() : eG()));
    chk({req, " xOut"}, {1'b0, xOut}, {1'b0, ex});
    chk({req, " yOut"}, {1'b0, yOut}, {1'b0, ey});
    chk({req, " qOut"}, {1'b0, qOut}, {1'b0, cfgEn ? 1'b0 : mQ});
    chk({req, " rdB"}, rdB, (cfgEn || mMd != 2'd1) ? 2'b00 : {mG[gIn], mF[gIn]});
    @(posedge clk);
    d = eD();
    if (!cfgEn && wrEn) begin
      if (mMd == 2'd1) begin mF[fIn] = wrData[0]; mG[fIn] = wrData[1]; end
      else if (mMd == 2'd2) begin
        if (hExt) mG[fIn] = wrData[0]; else mF[fIn] = wrData[0];
      end
    end
    if (regRst) mQ = 1'b0;
    else if (regCe && !cfgEn) mQ = d;
    @(negedge clk);
  endtask

  task automatic lfStep();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  // R1 R7: load chain with regCe held high and random inputs
  task automatic load(logic [53:0] v);
    cfgEn = 1; regCe = 1; regRst = 0; wrEn = 1;
    for (int i = 0; i < 54; i++) begin
      cfgData = v[i];
      lfStep(); fIn = lf[3:0]; gIn = lf[7:4]; hExt = lf[8]; wrData = lf[10:9];
      cycle("R7");
    end
    cfgEn = 0; regCe = 0; wrEn = 0;
    {mMd, mYQ, mXQ, mD, mYH, mXH, mS2, mS1, mS0, mH, mG, mF} = v;
    cycle("R7 hold");
  endtask

  task automatic sweep(string req, bit withExt);
    for (int e = 0; e < (withExt ? 2 : 1); e++)
      for (int a = 0; a < 256; a++) begin
        fIn = a[3:0]; gIn = a[7:4]; hExt = e[0];
        cycle(req);
      end
  endtask

  initial begin
    @(negedge clk);
    regRst = 1; regCe = 1;
    cycle("R6 reset");
    regRst = 0; regCe = 0;
    cycle("R6 reset state");

    // R1 R2 R12: logic mode, plain F and G
    load(mkCfg(16'hA4E1, 16'h5F08, 8'h96, 2'd3, 2'd3, 2'd3, 0, 0, 2'd0, 0, 0, 2'd0));
    sweep("R1 R2 R12", 0);
    // R3 R4: H from F, G, ext on both outputs
    load(mkCfg(16'h6996, 16'hF0C3, 8'h1D, 2'd0, 2'd1, 2'd2, 1, 1, 2'd0, 0, 0, 2'd3));
    sweep("R3 R4", 1);
    // R3: other select codes, including constant 0
    load(mkCfg(16'h3C5A, 16'h8001, 8'hB4, 2'd2, 2'd3, 2'd0, 1, 0, 2'd0, 0, 0, 2'd0));
    sweep("R3", 1);

    // R4 R5 R6: register sources, enables, reset priority
    for (int ds = 0; ds < 4; ds++) begin
      load(mkCfg(16'h7A2C, 16'h19E4, 8'h6B, 2'd0, 2'd1, 2'd2, 0, 1, ds[1:0], 1, ds[0], 2'd0));
      for (int c = 0; c < 80; c++) begin
        lfStep();
        fIn = lf[3:0]; gIn = lf[7:4]; hExt = lf[8];
        regCe = lf[9] | lf[11]; regRst = (lf[14:12] == 3'b111);
        cycle("R4 R5 R6");
      end
      regRst = 0; regCe = 1; fIn = 4'hF; cycle("R5");
      regCe = 0;
    end
    // R7: reload keeps the register value
    load(mkCfg(16'h0000, 16'h0000, 8'h00, 2'd3, 2'd3, 2'd3, 0, 0, 2'd0, 1, 1, 2'd0));
    cycle("R7 q kept");

    // R8 R9: 16x2 dual port
    load(mkCfg(16'h0000, 16'hFFFF, 8'h00, 2'd3, 2'd3, 2'd3, 0, 0, 2'd0, 0, 0, 2'd1));
    wrEn = 1;
    for (int a = 0; a < 16; a++) begin
      fIn = a[3:0]; gIn = 4'(a + 1); wrData = 2'((a * 3 + 1) & 3);
      cycle("R8 write");
    end
    wrEn = 0;
    sweep("R8 R9", 0);
    for (int c = 0; c < 64; c++) begin
      lfStep(); wrEn = lf[0]; fIn = lf[4:1]; gIn = lf[0] ? lf[4:1] : lf[8:5]; wrData = lf[10:9];
      cycle("R9 same contents");
    end
    wrEn = 0;

    // R10 R12: 32x1 single port
    load(mkCfg(16'hFFFF, 16'h0000, 8'h00, 2'd3, 2'd3, 2'd3, 0, 0, 2'd0, 0, 0, 2'd2));
    wrEn = 1;
    for (int a = 0; a < 32; a++) begin
      fIn = a[3:0]; hExt = a[4]; wrData = {1'b1, ^(a * 5)};
      cycle("R10 write");
    end
    wrEn = 0;
    sweep("R10 R12", 1);

    // R11: writes in logic mode leave tables unchanged
    load(mkCfg(16'hC3A5, 16'h5A3C, 8'h00, 2'd3, 2'd3, 2'd3, 0, 0, 2'd0, 0, 0, 2'd0));
    wrEn = 1;
    for (int a = 0; a < 32; a++) begin
      fIn = a[3:0]; gIn = a[3:0]; hExt = a[4]; wrData = a[0] ? 2'b11 : 2'b00;
      cycle("R11 write ignored");
    end
    wrEn = 0;
    sweep("R11", 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule